// File: doc/BRIEF.md
# Slave FIFO Write Controller

This block drains a first-word-fall-through FIFO inside the chip into an external USB bridge device that runs as an 8-bit slave FIFO. Everything runs on one interface clock. When the FIFO has data and the bridge reports room, the block pops one byte. Two cycles later it presents that byte on the bus with a one-cycle active-low write strobe. Every pin toward the bridge comes straight from a flop, so all pins change on the same clock edge.

Packets have a fixed length of `PKT_LEN` bytes, 482 by default. After the last byte of a packet, the block issues a one-cycle active-low packet-end strobe. That strobe never shares a cycle with a write. The bus only ever drives toward the bridge. The read and output-enable strobes stay inactive, and the endpoint address is fixed.

A debug option, `MARK_IDLE`, makes the last byte written before the controller falls back to idle carry bit `MARK_BIT` set. The controller falls back to idle when the FIFO drains. With the option on, a capture on the host shows where each burst ended.

Top module: `slave_fifo_writer`

## Requirements
- R1: `ep_addr` always reads binary 10. `rd_n` and `oe_n` are always 1.
- R2: `src_pop` is 1 in a cycle only if `src_valid` and `bridge_room` are both 1 in that cycle and reset is low.
- R3: A pop in cycle n gives `wr_n` = 0 in cycle n+2, with `bus_data` equal to the popped byte (bit 6 may be changed by R6). In every other cycle `wr_n` is 1.
- R4: The pop that brings the byte count since reset to a multiple of `PKT_LEN` (482) is the final pop of a packet. If that pop happens in cycle n, `pktend_n` = 0 in cycle n+3 only. `pktend_n` is never 0 in a cycle where `wr_n` is 0.
- R5: No pop occurs in the cycle right after a packet's final pop, whatever the inputs are.
- R6: With `MARK_IDLE`=1, a popped byte gets bit 6 set on the bus if two things hold: it is not a packet's final byte, and no pop follows in the next cycle. Every other byte is written unchanged.
- R7: While `rst` is 1 there are no pops. In the cycle after a reset edge, `wr_n` and `pktend_n` are both 1. Reset also restarts the packet byte count at zero.
- R8: Pauses in `src_valid` and `bridge_room` inside a packet do not move packet boundaries. Writing resumes as soon as both inputs are high again, and packet-end still follows every 482nd pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | 1 | Internal FIFO is non-empty |
| src_data | input | 8 | Head word of the internal FIFO |
| src_pop | output | 1 | Pop the internal FIFO this cycle |
| bridge_room | input | 1 | Bridge endpoint not full (high = room) |
| bus_data | output | 8 | Data bus toward the bridge |
| wr_n | output | 1 | Active-low write strobe |
| pktend_n | output | 1 | Active-low packet-end strobe |
| rd_n | output | 1 | Read strobe, held inactive high |
| oe_n | output | 1 | Output enable, held inactive high |
| ep_addr | output | 2 | Endpoint address, fixed at binary 10 |

## Verification
The assertions assume three things about the inputs. `src_data` already shows the head word in the cycle that `src_valid` is high. `bridge_room` is already synchronous to `clk`. A pop removes exactly one word. The bench models the FIFO as a counter, so each pop advances to a fresh byte pattern that keeps bit 6 clear. A marked byte therefore always differs from the data it came from. The bench drives `src_valid` and `bridge_room` on falling edges only, so both are stable at every rising edge, just as they are for the real FIFO and flag.

// File: rtl/sfw_pkg.sv
package sfw_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WRITE = 2'd1,
      ST_CLOSE = 2'd2
   } sfw_state_e;
endpackage

// File: rtl/sfw_pop_ctrl.sv
module sfw_pop_ctrl
   import sfw_pkg::*;
#(
   parameter int PKT_LEN = 482
) (
   input  logic clk,
   input  logic rst,
   input  logic src_valid,
   input  logic bridge_room,
   output logic pop,
   output logic pop_final,
   output logic leave_write
);
   localparam int CNT_W = (PKT_LEN > 2) ? $clog2(PKT_LEN) : 1;
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PKT_LEN - 1);

   sfw_state_e state_q, state_d;
   logic [CNT_W-1:0] cnt_q;

   // pops are blocked for the one cycle that follows the last byte of a packet
   assign pop         = !rst && (state_q != ST_CLOSE) && src_valid && bridge_room;
   assign pop_final   = pop && (cnt_q == LAST_IDX);
   assign leave_write = (state_q == ST_WRITE) && !pop;

   always_comb begin
      if (pop_final)  state_d = ST_CLOSE;
      else if (pop)   state_d = ST_WRITE;
      else            state_d = ST_IDLE;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         if (pop_final)  cnt_q <= '0;
         else if (pop)   cnt_q <= cnt_q + 1'b1;
      end
   end

   // R4
   count_range_chk: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= LAST_IDX);

   // R5
   close_once_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_CLOSE) |=> (state_q != ST_CLOSE));
endmodule

// File: rtl/sfw_stage.sv
module sfw_stage #(
   parameter int DATA_W    = 8,
   parameter bit MARK_IDLE = 1'b1,
   parameter int MARK_BIT  = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              pop,
   input  logic              pop_final,
   input  logic [DATA_W-1:0] src_data,
   input  logic              leave_write,
   output logic              stg_vld,
   output logic              stg_last,
   output logic [DATA_W-1:0] out_data
);
   logic [DATA_W-1:0] stg_data;

   always_ff @(posedge clk) begin
      if (rst) begin
         stg_vld  <= 1'b0;
         stg_last <= 1'b0;
         stg_data <= '0;
      end else begin
         stg_vld  <= pop;
         stg_last <= pop_final;
         if (pop) stg_data <= src_data;
      end
   end

   generate
      if (MARK_IDLE) begin : g_mark
         localparam logic [DATA_W-1:0] MARK_MASK = DATA_W'(1) << MARK_BIT;
         logic mark_now;
         assign mark_now = stg_vld && !stg_last && leave_write;
         assign out_data = mark_now ? (stg_data | MARK_MASK) : stg_data;
      end else begin : g_plain
         assign out_data = stg_data;
      end
   endgenerate

   // R5
   last_needs_vld_chk: assert property (@(posedge clk) disable iff (rst)
      stg_last |-> stg_vld);
endmodule

// File: rtl/sfw_out_regs.sv
module sfw_out_regs #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              stg_vld,
   input  logic              stg_last,
   input  logic [DATA_W-1:0] out_data,
   output logic [DATA_W-1:0] bus_data,
   output logic              wr_n,
   output logic              pktend_n
);
   logic pend_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         bus_data <= '0;
         wr_n     <= 1'b1;
         pend_q   <= 1'b0;
         pktend_n <= 1'b1;
      end else begin
         wr_n     <= !stg_vld;
         if (stg_vld) bus_data <= out_data;
         pend_q   <= stg_vld && stg_last;
         pktend_n <= !pend_q;
      end
   end

   // R4
   pe_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !pktend_n |-> wr_n);

   // R4
   pe_single_chk: assert property (@(posedge clk) disable iff (rst)
      !pktend_n |=> pktend_n);
endmodule

// File: rtl/slave_fifo_writer.sv
module slave_fifo_writer #(
   parameter int         DATA_W    = 8,
   parameter int         PKT_LEN   = 482,
   parameter bit         MARK_IDLE = 1'b1,
   parameter int         MARK_BIT  = 6,
   parameter logic [1:0] EP_ADDR   = 2'b10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              src_valid,
   input  logic [DATA_W-1:0] src_data,
   output logic              src_pop,
   input  logic              bridge_room,
   output logic [DATA_W-1:0] bus_data,
   output logic              wr_n,
   output logic              pktend_n,
   output logic              rd_n,
   output logic              oe_n,
   output logic [1:0]        ep_addr
);
   generate
      if (PKT_LEN < 2) begin : g_bad_len
         $error("PKT_LEN must be at least 2");
      end
      if (MARK_BIT >= DATA_W) begin : g_bad_bit
         $error("MARK_BIT must index into the data word");
      end
   endgenerate

   logic pop_final, leave_write;
   logic stg_vld, stg_last;
   logic [DATA_W-1:0] out_data;

   assign rd_n    = 1'b1;
   assign oe_n    = 1'b1;
   assign ep_addr = EP_ADDR;

   sfw_pop_ctrl #(.PKT_LEN(PKT_LEN)) u_ctrl (
      .clk(clk), .rst(rst), .src_valid(src_valid), .bridge_room(bridge_room),
      .pop(src_pop), .pop_final(pop_final), .leave_write(leave_write));

   sfw_stage #(.DATA_W(DATA_W), .MARK_IDLE(MARK_IDLE), .MARK_BIT(MARK_BIT)) u_stage (
      .clk(clk), .rst(rst), .pop(src_pop), .pop_final(pop_final),
      .src_data(src_data), .leave_write(leave_write),
      .stg_vld(stg_vld), .stg_last(stg_last), .out_data(out_data));

   sfw_out_regs #(.DATA_W(DATA_W)) u_out (
      .clk(clk), .rst(rst), .stg_vld(stg_vld), .stg_last(stg_last),
      .out_data(out_data), .bus_data(bus_data), .wr_n(wr_n), .pktend_n(pktend_n));

   // R2
   pop_guard_chk: assert property (@(posedge clk) disable iff (rst)
      stg_vld |-> $past(src_valid && bridge_room));

   // R3
   wr_follow_chk: assert property (@(posedge clk) disable iff (rst)
      $past(src_pop, 2) |-> !wr_n);

   // R3
   wr_cause_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_n |-> $past(src_pop, 2));

   // R4
   pktend_after_wr_chk: assert property (@(posedge clk) disable iff (rst)
      !pktend_n |-> $past(!wr_n));

   // R5
   close_gap_chk: assert property (@(posedge clk) disable iff (rst)
      stg_last |-> !src_pop);

   // R7
   reset_idle_chk: assert property (@(posedge clk)
      rst |=> (wr_n && pktend_n));
endmodule

// File: tb/tb_slave_fifo_writer.sv
module tb_slave_fifo_writer;
   localparam int PKT = 482;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic src_valid = 1'b0;
   logic bridge_room = 1'b0;
   logic [7:0] src_data = 8'h00;
   logic src_pop, wr_n, pktend_n, rd_n, oe_n;
   logic [7:0] bus_data;
   logic [1:0] ep_addr;

   always #4 clk = ~clk;

   slave_fifo_writer dut (
      .clk(clk), .rst(rst), .src_valid(src_valid), .src_data(src_data),
      .src_pop(src_pop), .bridge_room(bridge_room), .bus_data(bus_data),
      .wr_n(wr_n), .pktend_n(pktend_n), .rd_n(rd_n), .oe_n(oe_n), .ep_addr(ep_addr));

   int errors = 0, checks = 0, cyc = 0;
   bit done = 0;
   int idx = 0, cnt = 0, pe_seen = 0, pe_exp = 0, writes = 0;
   bit p1, p2, p3, f1, f2, f3;
   logic [7:0] d1, d2;

   // {src_valid, bridge_room} per cycle
   localparam logic [1:0] VEC [0:15] = '{
      2'b11, 2'b11, 2'b10, 2'b11, 2'b01, 2'b11, 2'b11, 2'b11,
      2'b00, 2'b11, 2'b10, 2'b10, 2'b11, 2'b01, 2'b11, 2'b11 };

   function automatic logic [7:0] pat(int i);
      return {i[5], 2'b00, i[4:0]};
   endfunction

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   task automatic clear_model();
      p1 = 0; p2 = 0; p3 = 0; f1 = 0; f2 = 0; f3 = 0;
      d1 = 0; d2 = 0; cnt = 0;
   endtask

   task automatic step(bit v, bit r);
      logic [7:0] exp_bus;
      bit e, fin;
      @(negedge clk);
      chk(ep_addr == 2'b10 && rd_n && oe_n, "R1", {ep_addr, rd_n, oe_n}, 4'b1011);
      chk(wr_n == !p2, "R3", wr_n, !p2);
      if (p2) begin
         exp_bus = d2 | ((!p1 && !f2) ? 8'h40 : 8'h00);
         chk(bus_data == exp_bus, (exp_bus != d2) ? "R6" : "R3", bus_data, exp_bus);
         writes++;
      end
      chk(pktend_n == !f3, "R4", pktend_n, !f3);
      if (!pktend_n) pe_seen++;
      if (f3) pe_exp++;
      if (p1) idx++;
      src_valid = v; bridge_room = r; src_data = pat(idx);
      #1;
      e = v && r && !f1;
      chk(src_pop == e, (f1 && v && r) ? "R5" : "R2", src_pop, e);
      fin = e && (cnt == PKT - 1);
      if (e) cnt = fin ? 0 : cnt + 1;
      p3 = p2; p2 = p1; p1 = e;
      f3 = f2; f2 = f1; f1 = fin;
      d2 = d1; d1 = src_data;
   endtask

   task automatic do_reset(int n);
      rst = 1'b1;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         src_valid = 1'b1; bridge_room = 1'b1;
         #1;
         chk(!src_pop, "R7", src_pop, 0);
         if (i > 0) chk(wr_n && pktend_n, "R7", {wr_n, pktend_n}, 2'b11);
      end
      clear_model();
      @(negedge clk);
      rst = 1'b0; src_valid = 1'b0; bridge_room = 1'b0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         finish_run();
      end
   end

   initial begin
      clear_model();
      do_reset(4);
      // table walk: mixed gaps in data and room
      for (int rep = 0; rep < 40; rep++)
         for (int k = 0; k < 16; k++)
            step(VEC[k][1], VEC[k][0]);
      // R8: long stream with sparse gaps across packet boundaries
      for (int k = 0; k < 1100; k++)
         step((k % 37) != 5, (k % 53) != 11);
      // R8: room held low blocks writes even with data present
      writes = 0;
      for (int k = 0; k < 20; k++) step(1'b1, 1'b0);
      chk(writes <= 2, "R8", writes, 2);
      // R7: reset mid-packet restarts the count
      do_reset(3);
      pe_seen = 0; pe_exp = 0;
      for (int k = 0; k < PKT + 10; k++) step(1'b1, 1'b1);
      chk(pe_seen == 1 && pe_exp == 1, "R7", pe_seen, 1);
      for (int k = 0; k < 6; k++) step(1'b0, 1'b1);
      chk(pe_seen == pe_exp, "R4", pe_seen, pe_exp);
      finish_run();
   end
endmodule